// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block sits in front of a program flash controller and decides, one command at a time, whether a program or erase request may proceed. It resolves the 21-bit byte address of the request to one of thirteen sectors of unequal size in a 2 MB space. It then weighs three protection sources against that sector: a reversible write lock per sector, a permanent one-time-programmable (OTP) mark per sector, and an array-wide read-protection switch that also forbids writes everywhere.

Protection can be lifted for a while by writing two 32-bit key words in order. After a correct pair, reversible write locks and the array-wide protection stop blocking commands until a re-lock command or a reset. OTP sectors stay closed under all conditions. The configured protection arrives on static configuration inputs, so a reset always brings the block back to that configuration. Each accepted command produces one registered response a cycle later. The response carries the grant decision, the resolved sector, and error pulses.

Top module: `flash_guard`

## Requirements
- R1: The sector reported in a response follows the address layout: eight 16 KB sectors 0..7 starting at 0x000000, sector 8 (128 KB) at 0x020000, sector 9 (256 KB) at 0x040000, and sectors 10, 11 and 12 (512 KB each) at 0x080000, 0x100000 and 0x180000.
- R2: A program or erase to a sector whose `cfg_wlock` bit is set, while no unlock is in effect, is refused with `prot_err` high in the response cycle.
- R3: A program or erase to a sector whose `cfg_otp` bit is set is always refused with `prot_err`, including while an unlock is in effect.
- R4: The key is the word 0xA5C30F1E followed by the word 0x5A3CF0E1, each given as a `pwd_valid` cycle. A wrong word at either step cancels the sequence, leaves `unlocked` unchanged, and pulses `prot_err` in the cycle after that word.
- R5: After a correct key pair, `unlocked` is high from the next cycle. Write locks and array-wide protection then no longer refuse commands. The unlock lasts until a re-lock command or a reset.
- R6: `cmd_op` encodes 0 = no operation, 1 = program page, 2 = erase sector, 3 = re-lock. A re-lock is granted, clears `unlocked`, and drops any half-entered key sequence.
- R7: While `cfg_rdprot` is high and no unlock is in effect, every sector is treated as write protected.
- R8: A program address with any of its low 8 bits set (not 256-byte aligned) is refused with `seq_err` high and `prot_err` low, whatever the protection of the sector.
- R9: Erase commands take any address inside a sector; no alignment is required.
- R10: Each command with a nonzero `cmd_op` yields exactly one `rsp_valid` cycle, on the cycle after it is presented. An opcode of 0 yields no response.
- R11: Bit i of `sec_locked` is high exactly when sector i would currently refuse a program or erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wlock | input | 13 | Configured reversible write lock per sector |
| cfg_otp | input | 13 | Configured permanent lock per sector |
| cfg_rdprot | input | 1 | Array-wide protection enable |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command opcode (see R6) |
| cmd_addr | input | 21 | Byte address of the command |
| pwd_valid | input | 1 | Key word present this cycle |
| pwd_data | input | 32 | Key word |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Command may proceed |
| rsp_sector | output | 4 | Resolved sector index |
| prot_err | output | 1 | Protection refusal or key mismatch pulse |
| seq_err | output | 1 | Misaligned program pulse |
| sec_locked | output | 13 | Current effective lock per sector |
| unlocked | output | 1 | Temporary unlock in effect |

## Verification
Program commands are sent to the first and last page of sectors on both sides of every size change. A wrong sector index here shows up as a wrong `rsp_sector` or as a wrong lock decision on a neighbour. The same addresses are then sent under three lock states: locked, unlocked after a key, and re-locked. This separates reversible locks from OTP marks, because only the former change. Key entries that are wrong at the first word or at the second word show whether a half sequence is ever honoured. A reset with array-wide protection enabled shows that the global switch is lifted by the key but never opens an OTP sector. Misaligned programs aimed at locked and open sectors confirm that the alignment fault takes priority, while unaligned erases are shown to be accepted.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
    localparam int ADDR_W    = 21;
    localparam int N_SEC     = 13;
    localparam int SEC_W     = $clog2(N_SEC);
    localparam int PAGE_LOG  = 8;
    localparam int SMALL_N   = 8;
    localparam int SMALL_LOG = 14;
    localparam int MID_LOG   = 17;
    localparam int BIG_LOG   = 19;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_PROG   = 2'd1,
        OP_ERASE  = 2'd2,
        OP_RELOCK = 2'd3
    } op_e;

    typedef struct packed {
        logic             valid;
        logic             grant;
        logic [SEC_W-1:0] sector;
        logic             prot_err;
        logic             seq_err;
        logic             is_wr;
    } rsp_t;

    // start address of sector idx
    function automatic logic [ADDR_W-1:0] sec_base(int idx);
        logic [ADDR_W-1:0] b;
        if (idx < SMALL_N)
            b = ADDR_W'(idx) << SMALL_LOG;
        else if (idx == SMALL_N)
            b = ADDR_W'(1) << MID_LOG;
        else if (idx == SMALL_N + 1)
            b = ADDR_W'(2) << MID_LOG;
        else
            b = ADDR_W'(idx - SMALL_N - 1) << BIG_LOG;
        return b;
    endfunction
endpackage

// File: rtl/fg_sector_map.sv
module fg_sector_map
    import flash_guard_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [SEC_W-1:0]  sector
);
    logic [N_SEC-1:0] above;

    for (genvar i = 0; i < N_SEC; i++) begin : g_cmp
        assign above[i] = (addr >= sec_base(i));
    end

    always_comb begin
        logic [SEC_W-1:0] cnt;
        cnt = '0;
        for (int i = 1; i < N_SEC; i++) begin
            cnt = cnt + SEC_W'(above[i]);
        end
        sector = cnt;
    end
endmodule

// File: rtl/fg_lock_eval.sv
module fg_lock_eval
    import flash_guard_pkg::*;
(
    input  logic [N_SEC-1:0] cfg_wlock,
    input  logic [N_SEC-1:0] cfg_otp,
    input  logic             cfg_rdprot,
    input  logic             unlocked,
    output logic [N_SEC-1:0] eff_lock
);
    for (genvar i = 0; i < N_SEC; i++) begin : g_sec
        assign eff_lock[i] = cfg_otp[i] | ((cfg_wlock[i] | cfg_rdprot) & ~unlocked);
    end
endmodule

// File: rtl/fg_pwd_seq.sv
module fg_pwd_seq #(
    parameter int              KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY0 = 32'hA5C3_0F1E,
    parameter logic [KEY_W-1:0] KEY1 = 32'h5A3C_F0E1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwd_valid,
    input  logic [KEY_W-1:0] pwd_data,
    input  logic             relock,
    output logic             unlocked,
    output logic             key_err
);
    typedef struct packed {
        logic stage;
        logic open;
        logic err;
    } pstate_t;

    pstate_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (pwd_valid) begin
            if (!s_q.stage) begin
                if (pwd_data == KEY0) s_d.stage = 1'b1;
                else                  s_d.err   = 1'b1;
            end else begin
                s_d.stage = 1'b0;
                if (pwd_data == KEY1) s_d.open = 1'b1;
                else                  s_d.err  = 1'b1;
            end
        end
        if (relock) begin
            s_d.open  = 1'b0;
            s_d.stage = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign unlocked = s_q.open;
    assign key_err  = s_q.err;

    // R5
    unlock_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.open) |-> ($past(pwd_valid) && $past(s_q.stage)));

    // R6
    relock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !s_q.open && !s_q.stage);

    // R4
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |-> $past(pwd_valid));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int              KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY0 = 32'hA5C3_0F1E,
    parameter logic [KEY_W-1:0] KEY1 = 32'h5A3C_F0E1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SEC-1:0]  cfg_wlock,
    input  logic [N_SEC-1:0]  cfg_otp,
    input  logic              cfg_rdprot,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              pwd_valid,
    input  logic [KEY_W-1:0]  pwd_data,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [SEC_W-1:0]  rsp_sector,
    output logic              prot_err,
    output logic              seq_err,
    output logic [N_SEC-1:0]  sec_locked,
    output logic              unlocked
);
    op_e              op;
    logic [SEC_W-1:0] map_sec;
    logic [N_SEC-1:0] eff_lock;
    logic             key_err;
    logic             relock;
    rsp_t             r_d, r_q;

    assign op     = op_e'(cmd_op);
    assign relock = cmd_valid && (op == OP_RELOCK);

    fg_sector_map u_map (
        .addr   (cmd_addr),
        .sector (map_sec)
    );

    fg_pwd_seq #(.KEY_W(KEY_W), .KEY0(KEY0), .KEY1(KEY1)) u_pwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwd_valid (pwd_valid),
        .pwd_data  (pwd_data),
        .relock    (relock),
        .unlocked  (unlocked),
        .key_err   (key_err)
    );

    fg_lock_eval u_lock (
        .cfg_wlock  (cfg_wlock),
        .cfg_otp    (cfg_otp),
        .cfg_rdprot (cfg_rdprot),
        .unlocked   (unlocked),
        .eff_lock   (eff_lock)
    );

    always_comb begin
        r_d = '0;
        if (cmd_valid && op != OP_NOP) begin
            r_d.valid  = 1'b1;
            r_d.sector = map_sec;
            unique case (op)
                OP_RELOCK: r_d.grant = 1'b1;
                OP_PROG: begin
                    r_d.is_wr = 1'b1;
                    if (cmd_addr[PAGE_LOG-1:0] != '0) r_d.seq_err  = 1'b1;
                    else if (eff_lock[map_sec])        r_d.prot_err = 1'b1;
                    else                               r_d.grant    = 1'b1;
                end
                OP_ERASE: begin
                    r_d.is_wr = 1'b1;
                    if (eff_lock[map_sec]) r_d.prot_err = 1'b1;
                    else                   r_d.grant    = 1'b1;
                end
                default: r_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid  = r_q.valid;
    assign rsp_grant  = r_q.grant;
    assign rsp_sector = r_q.sector;
    assign prot_err   = r_q.prot_err | key_err;
    assign seq_err    = r_q.seq_err;
    assign sec_locked = eff_lock;

    // R3
    otp_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.valid && r_q.grant && r_q.is_wr) |-> !cfg_otp[r_q.sector]);

    // R8
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.seq_err |-> (!r_q.grant && !r_q.prot_err));

    // R2
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.grant |-> !r_q.prot_err);

    // R10
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> $past(cmd_valid));

    // R1
    sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> (r_q.sector < SEC_W'(N_SEC)));
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
    import flash_guard_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SEC-1:0]  cfg_wlock = '0, cfg_otp = '0;
    logic              cfg_rdprot = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              pwd_valid = 1'b0;
    logic [31:0]       pwd_data = '0;
    logic              rsp_valid, rsp_grant, prot_err, seq_err, unlocked;
    logic [SEC_W-1:0]  rsp_sector;
    logic [N_SEC-1:0]  sec_locked;

    always #2 clk = ~clk;

    flash_guard u0 (.*);

    typedef struct {
        logic             grant;
        logic [SEC_W-1:0] sector;
        logic             prot;
        logic             seq;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0, bad = 0;
    bit   done = 1'b0;
    bit   m_unlk = 1'b0, m_stage = 1'b0;

    localparam logic [31:0] K0 = 32'hA5C3_0F1E;
    localparam logic [31:0] K1 = 32'h5A3C_F0E1;

    function automatic logic [SEC_W-1:0] ref_sec(logic [ADDR_W-1:0] a);
        if (a < 21'h020000)      return SEC_W'(a >> 14);
        else if (a < 21'h040000) return 4'd8;
        else if (a < 21'h080000) return 4'd9;
        else if (a < 21'h100000) return 4'd10;
        else if (a < 21'h180000) return 4'd11;
        else                     return 4'd12;
    endfunction

    function automatic logic ref_lock(int s);
        return cfg_otp[s] | ((cfg_wlock[s] | cfg_rdprot) & ~m_unlk);
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic do_reset(logic [N_SEC-1:0] wl, logic [N_SEC-1:0] otp, logic rp);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wlock = wl; cfg_otp = otp; cfg_rdprot = rp;
        m_unlk = 1'b0; m_stage = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_cmd(op_e op, logic [ADDR_W-1:0] a, string tag);
        exp_t e;
        int   s;
        @(negedge clk);
        s = int'(ref_sec(a));
        e.sector = ref_sec(a);
        e.tag = tag;
        e.grant = 1'b0; e.prot = 1'b0; e.seq = 1'b0;
        if (op == OP_RELOCK) e.grant = 1'b1;
        else if (op == OP_PROG && a[7:0] != 8'h00) e.seq = 1'b1;
        else if (ref_lock(s)) e.prot = 1'b1;
        else e.grant = 1'b1;
        if (op == OP_RELOCK) begin m_unlk = 1'b0; m_stage = 1'b0; end
        exp_q.push_back(e);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic send_key(logic [31:0] w, bit exp_err, string req);
        @(negedge clk);
        pwd_valid = 1'b1; pwd_data = w;
        if (!m_stage) begin
            if (w == K0) m_stage = 1'b1;
        end else begin
            m_stage = 1'b0;
            if (w == K1) m_unlk = 1'b1;
        end
        @(negedge clk);
        pwd_valid = 1'b0;
        check(prot_err == exp_err, req, "key prot_err", 32'(prot_err), 32'(exp_err));
        check(unlocked == m_unlk, req, "unlocked", 32'(unlocked), 32'(m_unlk));
    endtask

    task automatic check_status(string req);
        logic [N_SEC-1:0] v;
        for (int i = 0; i < N_SEC; i++) v[i] = ref_lock(i);
        @(negedge clk);
        check(sec_locked == v, req, "sec_locked", 32'(sec_locked), 32'(v));
    endtask

    // monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected response", 32'(rsp_sector), 32'hFFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({rsp_grant, rsp_sector, prot_err, seq_err} == {e.grant, e.sector, e.prot, e.seq},
                      e.tag, "grant/sector/prot/seq",
                      32'({rsp_grant, rsp_sector, prot_err, seq_err}),
                      32'({e.grant, e.sector, e.prot, e.seq}));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // config A: write locks on 3 and 9, OTP on 11
        do_reset(13'h0208, 13'h0800, 1'b0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10", "reset rsp_valid", 32'(rsp_valid), 0);
        check(unlocked == 1'b0, "R5", "reset unlocked", 32'(unlocked), 0);
        check_status("R11");

        // R1 boundaries, R2 locks, R3 otp
        send_cmd(OP_PROG, 21'h000000, "R1 s0 first page");
        send_cmd(OP_PROG, 21'h00C100, "R2 s3 locked");
        send_cmd(OP_PROG, 21'h01FF00, "R1 s7 last page");
        send_cmd(OP_PROG, 21'h020000, "R1 s8 first page");
        send_cmd(OP_PROG, 21'h03FF00, "R1 s8 last page");
        send_cmd(OP_PROG, 21'h040000, "R2 s9 locked first");
        send_cmd(OP_PROG, 21'h07FF00, "R2 s9 locked last");
        send_cmd(OP_PROG, 21'h080000, "R1 s10 first page");
        send_cmd(OP_PROG, 21'h100000, "R3 s11 otp");
        send_cmd(OP_PROG, 21'h17FF00, "R3 s11 otp last");
        send_cmd(OP_PROG, 21'h180000, "R1 s12 first page");
        send_cmd(OP_PROG, 21'h1FFF00, "R1 s12 last page");
        // R8 alignment
        send_cmd(OP_PROG, 21'h000010, "R8 misaligned open");
        send_cmd(OP_PROG, 21'h00C001, "R8 misaligned locked");
        // R9 erase no alignment
        send_cmd(OP_ERASE, 21'h004321, "R9 erase s1 unaligned");
        send_cmd(OP_ERASE, 21'h050001, "R9 erase s9 locked");
        send_cmd(OP_ERASE, 21'h123457, "R3 erase s11 otp");
        // R10 nop ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 21'h000000;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(rsp_valid == 1'b0, "R10", "nop no response", 32'(rsp_valid), 0);

        // R4 wrong keys
        send_key(32'h1234_5678, 1'b1, "R4");
        send_key(K0, 1'b0, "R4");
        send_key(32'h0BAD_0BAD, 1'b1, "R4");
        send_key(K1, 1'b1, "R4");
        send_cmd(OP_PROG, 21'h00C000, "R4 still locked");
        // R5 correct pair
        send_key(K0, 1'b0, "R5");
        send_key(K1, 1'b0, "R5");
        check_status("R11");
        send_cmd(OP_PROG, 21'h00C000, "R5 s3 unlocked");
        send_cmd(OP_ERASE, 21'h060000, "R5 s9 unlocked");
        send_cmd(OP_PROG, 21'h100000, "R3 otp while unlocked");
        // R6 relock
        send_cmd(OP_RELOCK, 21'h000000, "R6 relock");
        @(negedge clk);
        check(unlocked == 1'b0, "R6", "after relock", 32'(unlocked), 0);
        send_cmd(OP_PROG, 21'h00C000, "R6 s3 relocked");
        // R6 relock drops half key
        send_key(K0, 1'b0, "R6");
        send_cmd(OP_RELOCK, 21'h000000, "R6 relock mid key");
        send_key(K1, 1'b1, "R6");

        // config B: array-wide protection, OTP on 12
        do_reset(13'h0000, 13'h1000, 1'b1);
        check_status("R7");
        send_cmd(OP_PROG, 21'h014000, "R7 s5 protected");
        send_cmd(OP_ERASE, 21'h090000, "R7 s10 protected");
        send_key(K0, 1'b0, "R7");
        send_key(K1, 1'b0, "R7");
        check_status("R11");
        send_cmd(OP_PROG, 21'h014000, "R7 s5 unlocked");
        send_cmd(OP_PROG, 21'h1C0000, "R3 s12 otp");
        send_cmd(OP_ERASE, 21'h090000, "R7 s10 unlocked");
        // R5 reset restores
        do_reset(13'h0000, 13'h1000, 1'b1);
        @(negedge clk);
        check(unlocked == 1'b0, "R5", "reset clears unlock", 32'(unlocked), 0);
        send_cmd(OP_PROG, 21'h014000, "R5 locked after reset");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10", "responses outstanding", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule